// File: doc/BRIEF.md
# Packet-Addressed Configuration Register Bank

This block keeps a small bank of narrow configuration registers and serves them over one command stream. Each command word either stores a value into one register or asks for a register's contents. Every command carries its own opcode and register index. A read answers with a reply word on a second stream. The reply repeats the index next to the data, so a consumer can match answers to questions without keeping its own state. A write produces no reply. The whole bank is also driven out in parallel on a flat bus, for logic that consumes the settings directly.

Both streams use valid/ready. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high, and a reply transfers the same way on `reply_valid` and `reply_ready`. Back-pressure works as follows. Once a read has been taken, `cmd_ready` stays low until its reply has been accepted, so the bank holds at most one reply in flight. A later command can never overtake that reply. While the consumer stalls, the reply word does not change. Register updates take effect on the edge that accepts the write, so a read accepted on any later edge sees the new value.

Top module: `pkt_regfile`

## Requirements
- R1: After reset every register reads zero on `regs_flat`, `reply_valid` is low and `cmd_ready` is high.
- R2: An accepted command with bit 8 = 1 stores bits [7:3] into the register whose index is in bits [2:0]. The new value shows in field `regs_flat[5*i +: 5]` one cycle after the accepting edge.
- R3: An accepted write never raises `reply_valid`.
- R4: An accepted command with bit 8 = 0 raises `reply_valid` on the next cycle. The reply word carries the register data in bits [7:3] and the echoed index in bits [2:0]; for example, register 0 holding 12 gives 96.
- R5: `cmd_ready` is low in every cycle in which `reply_valid` is high, so no command is taken while a reply waits.
- R6: While `reply_valid` is high and `reply_ready` is low, `reply_valid` stays high and `reply_data` does not change.
- R7: The cycle after a reply is accepted, `reply_valid` is low and `cmd_ready` is high again.
- R8: Indices at or above `NUM_REGS` (default 6) are unimplemented. A read of one returns zero data with the index echoed, and a write to one changes no register.
- R9: Register contents change only through accepted writes. Reads, commands offered while `cmd_ready` is low, and the data bits of a read leave `regs_flat` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Bank can take a command |
| cmd_data | input | 9 | Bit 8 opcode (1 write, 0 read), [7:3] write data, [2:0] index |
| reply_valid | output | 1 | Reply word offered |
| reply_ready | input | 1 | Consumer takes the reply |
| reply_data | output | 8 | [7:3] register data, [2:0] echoed index |
| regs_flat | output | 30 | All registers, register i in bits [5*i +: 5] |

## Verification
The hardest case to create is a command that is already offered while a reply is stalled. The bank must refuse it, keep the reply word frozen, and leave every register untouched.

After each read, the stimulus holds `reply_ready` low for a random number of cycles. During that stall it keeps `cmd_valid` high with a write command whose payload would be visible if it got through. The bench then checks `regs_flat`, the reply word and `cmd_ready` in every stalled cycle. Directed reads and writes to the unimplemented indices 6 and 7 cover the zero-data and no-effect cases.

// File: rtl/pkt_regfile_pkg.sv
package pkt_regfile_pkg;

  // opcode carried in the top bit of a command word
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } prf_op_e;

endpackage

// File: rtl/prf_cmd_decode.sv
module prf_cmd_decode
  import pkt_regfile_pkg::*;
#(
  parameter int DATA_W = 5,
  parameter int IDX_W  = 3,
  localparam int CMD_W = 1 + DATA_W + IDX_W
) (
  input  logic              cmd_valid,
  input  logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              wr_en,
  output logic              rd_en,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] wdata
);

  prf_op_e op;
  logic    take;

  always_comb begin
    op    = prf_op_e'(cmd_data[CMD_W-1]);
    take  = cmd_valid && cmd_ready;
    wr_en = take && (op == OP_WRITE);
    rd_en = take && (op == OP_READ);
    idx   = cmd_data[IDX_W-1:0];
    wdata = cmd_data[IDX_W +: DATA_W];
  end

endmodule

// File: rtl/prf_reg_store.sv
module prf_reg_store #(
  parameter int DATA_W   = 5,
  parameter int IDX_W    = 3,
  parameter int NUM_REGS = 6,
  localparam int FLAT_W  = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [FLAT_W-1:0] regs_flat
);

  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)   regs[g] <= '0;
      else if (hit) regs[g] <= wr_data;
    end

    assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
  end

  // unimplemented indices fall through to zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = regs[i];
    end
  end

endmodule

// File: rtl/prf_reply_gen.sv
module prf_reply_gen #(
  parameter int DATA_W  = 5,
  parameter int IDX_W   = 3,
  localparam int RPLY_W = DATA_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              reply_ready,
  output logic              reply_valid,
  output logic [RPLY_W-1:0] reply_data,
  output logic              cmd_ready
);

  logic pending_q;
  logic [RPLY_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      word_q    <= '0;
    end else if (rd_en) begin
      pending_q <= 1'b1;
      word_q    <= {rd_data, rd_idx};
    end else if (pending_q && reply_ready) begin
      pending_q <= 1'b0;
    end
  end

  assign reply_valid = pending_q;
  assign reply_data  = word_q;
  assign cmd_ready   = !pending_q;

endmodule

// File: rtl/pkt_regfile.sv
module pkt_regfile #(
  parameter int DATA_W   = 5,
  parameter int IDX_W    = 3,
  parameter int NUM_REGS = 6,
  localparam int CMD_W   = 1 + DATA_W + IDX_W,
  localparam int RPLY_W  = DATA_W + IDX_W,
  localparam int FLAT_W  = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              reply_valid,
  input  logic              reply_ready,
  output logic [RPLY_W-1:0] reply_data,
  output logic [FLAT_W-1:0] regs_flat
);

  logic              wr_en, rd_en;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] wdata, rdata;

  prf_cmd_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_data  (cmd_data),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .idx       (idx),
    .wdata     (wdata)
  );

  prf_reg_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (idx),
    .wr_data   (wdata),
    .rd_idx    (idx),
    .rd_data   (rdata),
    .regs_flat (regs_flat)
  );

  prf_reply_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_reply (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .rd_idx      (idx),
    .rd_data     (rdata),
    .reply_ready (reply_ready),
    .reply_valid (reply_valid),
    .reply_data  (reply_data),
    .cmd_ready   (cmd_ready)
  );

endmodule

// File: rtl/pkt_regfile_chk.sv
module pkt_regfile_chk #(
  parameter int DATA_W   = 5,
  parameter int IDX_W    = 3,
  parameter int NUM_REGS = 6,
  localparam int CMD_W   = 1 + DATA_W + IDX_W,
  localparam int RPLY_W  = DATA_W + IDX_W,
  localparam int FLAT_W  = NUM_REGS * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [CMD_W-1:0]  cmd_data,
  input logic              reply_valid,
  input logic              reply_ready,
  input logic [RPLY_W-1:0] reply_data,
  input logic [FLAT_W-1:0] regs_flat
);

  logic acc_wr, acc_rd;
  assign acc_wr = cmd_valid && cmd_ready && cmd_data[CMD_W-1];
  assign acc_rd = cmd_valid && cmd_ready && !cmd_data[CMD_W-1];

  // R5
  busy_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid |-> !cmd_ready);

  // R6
  reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid && !reply_ready) |=> (reply_valid && $stable(reply_data)));

  // R3
  write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> !reply_valid);

  // R4
  read_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> (reply_valid && reply_data[IDX_W-1:0] == $past(cmd_data[IDX_W-1:0])));

  // R7
  reply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid && reply_ready) |=> (!reply_valid && cmd_ready));

  // R9
  regs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> $stable(regs_flat));

endmodule

bind pkt_regfile pkt_regfile_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_data    (cmd_data),
  .reply_valid (reply_valid),
  .reply_ready (reply_ready),
  .reply_data  (reply_data),
  .regs_flat   (regs_flat)
);

// File: tb/test_pkt_regfile.sv
module test_pkt_regfile;

  localparam int NR = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [8:0] cmd_data = '0;
  logic       reply_valid;
  logic       reply_ready = 1'b0;
  logic [7:0] reply_data;
  logic [29:0] regs_flat;

  int checks = 0;
  int errors = 0;
  logic [4:0] model [8];

  always #5 clk = ~clk;

  pkt_regfile i_pkt_regfile (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .reply_valid(reply_valid), .reply_ready(reply_ready),
    .reply_data(reply_data), .regs_flat(regs_flat)
  );

  function automatic logic [29:0] exp_flat();
    logic [29:0] f = '0;
    for (int i = 0; i < NR; i++) f[i*5 +: 5] = model[i];
    return f;
  endfunction

  function automatic logic [7:0] exp_reply(input logic [2:0] ix);
    logic [4:0] d = (int'(ix) < NR) ? model[ix] : 5'd0;
    return {d, ix};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // call at a negedge
  task automatic do_write(input logic [2:0] ix, input logic [4:0] d);
    cmd_data = {1'b1, d, ix};
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (int'(ix) < NR) model[ix] = d;
    check("R2/R8 regs after write", 32'(regs_flat), 32'(exp_flat()));
    check("R3 no reply after write", 32'(reply_valid), 32'd0);
  endtask

  task automatic do_read(input logic [2:0] ix, input int stall);
    cmd_data = {1'b0, 5'($urandom), ix};
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    check("R4 reply valid", 32'(reply_valid), 32'd1);
    check("R4/R8 reply word", 32'(reply_data), 32'(exp_reply(ix)));
    // offer a write that must be refused during the stall
    cmd_data = {1'b1, 5'($urandom), 3'($urandom)};
    cmd_valid = (stall > 0);
    for (int k = 0; k < stall; k++) begin
      check("R5 ready low while busy", 32'(cmd_ready), 32'd0);
      @(negedge clk);
      check("R6 reply held valid", 32'(reply_valid), 32'd1);
      check("R6 reply word stable", 32'(reply_data), 32'(exp_reply(ix)));
      check("R9 refused write no effect", 32'(regs_flat), 32'(exp_flat()));
    end
    cmd_valid = 1'b0;
    reply_ready = 1'b1;
    @(negedge clk);
    reply_ready = 1'b0;
    check("R7 reply dropped", 32'(reply_valid), 32'd0);
    check("R7 ready restored", 32'(cmd_ready), 32'd1);
    check("R9 regs after read", 32'(regs_flat), 32'(exp_flat()));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 regs zero", 32'(regs_flat), 32'd0);
    check("R1 reply idle", 32'(reply_valid), 32'd0);
    check("R1 ready high", 32'(cmd_ready), 32'd1);

    // directed
    do_write(3'd0, 5'd0);
    do_write(3'd0, 5'd12);
    do_read(3'd0, 0);
    check("R4 example 12 -> 96", 32'(exp_reply(3'd0)), 32'd96);
    do_write(3'd5, 5'd31);
    do_read(3'd5, 3);
    do_write(3'd6, 5'd17);
    do_write(3'd7, 5'd9);
    do_read(3'd6, 2);
    do_read(3'd7, 0);
    do_read(3'd2, 4);

    // random
    for (int n = 0; n < 400; n++) begin
      logic [2:0] ix = 3'($urandom);
      if ($urandom_range(0, 1) == 1) do_write(ix, 5'($urandom));
      else do_read(ix, $urandom_range(0, 4));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule